// File: doc/BRIEF.md
# Serial Autobaud Lock Detector

This block sits between a raw asynchronous receive pin and the UART of a boot-time command port. Straight after reset, no baud rate is known. The host opens the link by sending one synchronisation character, 0x55. Sent LSB first with its start bit, that character gives nine cells of one bit each that alternate in level. The block times each cell in system clocks and averages them into a clocks-per-bit divisor. It checks that the cells agree with one another and then publishes the result.

Once a measurement is accepted, the block holds the divisor and a midpoint sample offset for the UART shift logic and raises a sticky locked flag. It also gives a single-cycle request so that the transmitter sends 'U' back, which tells the host that the channel is open. Until lock, the command layer must treat the line as closed. After lock, the receive line no longer affects this block. A measurement that is too short, too irregular or stalled is thrown away, and the block waits for the next falling edge.

Top module: `autobaud_lock`

## Requirements
- R1: After reset, locked_o and echo_req_o are 0, and divisor_o and half_o are 0. The divisor and half outputs stay 0 for as long as locked_o is 0.
- R2: When rx_i carries 0x55 (low start bit, then data bits LSB first, giving nine alternating cells) and every cell lasts D clocks, the block locks with divisor_o = D and half_o = floor(D/2).
- R3: The divisor is floor(sum of the first eight cell widths / 8), taken over the start bit through data bit 6. Cell-to-cell jitter is therefore averaged out.
- R4: Let M be that mean. If any of the nine cells (the start bit through data bit 7) is shorter than M - floor(M/4) or longer than M + floor(M/4), the measurement is rejected. The block stays unlocked, and a later valid character still locks.
- R5: A mean below MIN_DIV is rejected, and the block stays unlocked. A mean equal to MIN_DIV is accepted.
- R6: echo_req_o is a pulse exactly one cycle long. It is issued once per lock, in the same cycle in which locked_o rises.
- R7: Once locked, the block ignores any further activity on rx_i. locked_o stays 1, divisor_o and half_o hold their values, and no further echo request is made.
- R8: A cell that reaches 2^CNT_W - 1 clocks without a line edge aborts the measurement, and the block returns to waiting for a falling edge.
- R9: rx_i passes through SYNC_STAGES flip-flops. locked_o and echo_req_o become 1 on the (SYNC_STAGES+2)-th rising clock edge after the transition that ends data bit 7, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw serial receive line, idle high |
| divisor_o | output | CNT_W | Clocks per bit once locked, 0 before |
| half_o | output | CNT_W | Midpoint sample offset, divisor/2 |
| locked_o | output | 1 | Sticky flag: baud rate established |
| echo_req_o | output | 1 | One-cycle request to transmit 'U' |

## Verification
On every cycle, the assertions check the following. The echo request is a lone pulse that comes together with the rise of the lock flag. Lock is sticky and freezes both timing outputs. The outputs are zero while unlocked, and an accepted divisor is never below the minimum. Only the directed scenarios can show that the divisor matches the averaged cell widths, and where the tolerance window and the minimum period lie, counted exactly. They also cover recovery after a rejected, too-fast or stalled character, and the exact cycle in which lock appears after the final edge.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_MEAS  = 2'd1,
        ST_CHECK = 2'd2,
        ST_LOCK  = 2'd3
    } ab_state_e;

    // 0x55 with its start bit gives nine alternating cells; eight are averaged.
    localparam int unsigned AB_AVG_LOG2  = 3;
    localparam int unsigned AB_AVG_CELLS = 1 << AB_AVG_LOG2;
    localparam int unsigned AB_ALL_CELLS = AB_AVG_CELLS + 1;
    localparam int unsigned AB_CNT_CW    = $clog2(AB_ALL_CELLS + 1);

endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_o
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stage_d[g] = rx_i;
            end else begin : g_next
                assign stage_d[g] = stage_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= stage_d;
    end

    assign rx_o = stage_q[STAGES-1];
endmodule

// File: rtl/ab_cell_stats.sv
module ab_cell_stats import autobaud_pkg::*; #(
    parameter int unsigned CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          take_i,
    input  logic [CNT_W-1:0]              width_i,
    output logic [CNT_W+AB_AVG_LOG2-1:0]  sum_o,
    output logic [CNT_W-1:0]              min_o,
    output logic [CNT_W-1:0]              max_o,
    output logic [AB_CNT_CW-1:0]          count_o
);
    localparam int unsigned SUM_W = CNT_W + AB_AVG_LOG2;
    localparam logic [AB_CNT_CW-1:0] AVG_V = AB_CNT_CW'(AB_AVG_CELLS);

    typedef struct packed {
        logic [AB_CNT_CW-1:0] count;
        logic [SUM_W-1:0]     sum;
        logic [CNT_W-1:0]     mn;
        logic [CNT_W-1:0]     mx;
    } stats_t;

    stats_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.count = '0;
            s_d.sum   = '0;
            s_d.mn    = '1;
            s_d.mx    = '0;
        end else if (take_i) begin
            s_d.count = s_q.count + 1'b1;
            if (s_q.count < AVG_V) s_d.sum = s_q.sum + SUM_W'(width_i);
            if (width_i < s_q.mn)  s_d.mn  = width_i;
            if (width_i > s_q.mx)  s_d.mx  = width_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{count: '0, sum: '0, mn: '1, mx: '0};
        else        s_q <= s_d;
    end

    assign sum_o   = s_q.sum;
    assign min_o   = s_q.mn;
    assign max_o   = s_q.mx;
    assign count_o = s_q.count;
endmodule

// File: rtl/ab_judge.sv
module ab_judge import autobaud_pkg::*; #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned MIN_DIV = 8
) (
    input  logic [CNT_W+AB_AVG_LOG2-1:0] sum_i,
    input  logic [CNT_W-1:0]             min_i,
    input  logic [CNT_W-1:0]             max_i,
    output logic [CNT_W-1:0]             mean_o,
    output logic                         ok_o
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DIV);

    logic [CNT_W-1:0] slack;
    logic [CNT_W-1:0] lo;
    logic [CNT_W:0]   hi;

    always_comb begin
        mean_o = sum_i[CNT_W+AB_AVG_LOG2-1:AB_AVG_LOG2];
        slack  = {2'b00, mean_o[CNT_W-1:2]};
        lo     = mean_o - slack;
        hi     = {1'b0, mean_o} + {1'b0, slack};
        ok_o   = (min_i >= lo) && ({1'b0, max_i} <= hi) && (mean_o >= MIN_V);
    end
endmodule

// File: rtl/autobaud_lock.sv
module autobaud_lock import autobaud_pkg::*; #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned MIN_DIV     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    output logic [CNT_W-1:0] divisor_o,
    output logic [CNT_W-1:0] half_o,
    output logic             locked_o,
    output logic             echo_req_o
);
    localparam int unsigned SUM_W = CNT_W + AB_AVG_LOG2;
    localparam logic [CNT_W-1:0]     CNT_SAT  = '1;
    localparam logic [CNT_W-1:0]     CNT_ONE  = CNT_W'(1);
    localparam logic [AB_CNT_CW-1:0] LAST_IDX = AB_CNT_CW'(AB_ALL_CELLS - 1);

    typedef struct packed {
        ab_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             rx_prev;
        logic [CNT_W-1:0] divisor;
        logic [CNT_W-1:0] half;
        logic             locked;
        logic             echo;
    } regs_t;

    regs_t r_d, r_q;

    logic                 rx_s;
    logic                 line_edge;
    logic                 take;
    logic                 clear;
    logic [SUM_W-1:0]     st_sum;
    logic [CNT_W-1:0]     st_min;
    logic [CNT_W-1:0]     st_max;
    logic [AB_CNT_CW-1:0] st_count;
    logic [CNT_W-1:0]     mean;
    logic                 meas_ok;

    ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_i  (rx_i),
        .rx_o  (rx_s)
    );

    ab_cell_stats #(.CNT_W(CNT_W)) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .take_i  (take),
        .width_i (r_q.cnt),
        .sum_o   (st_sum),
        .min_o   (st_min),
        .max_o   (st_max),
        .count_o (st_count)
    );

    ab_judge #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_judge (
        .sum_i  (st_sum),
        .min_i  (st_min),
        .max_i  (st_max),
        .mean_o (mean),
        .ok_o   (meas_ok)
    );

    assign line_edge = rx_s ^ r_q.rx_prev;
    assign clear     = (r_q.state == ST_HUNT);

    always_comb begin
        r_d         = r_q;
        take        = 1'b0;
        r_d.rx_prev = rx_s;
        r_d.echo    = 1'b0;

        // cell timer: restarts on every edge, saturates on a stuck line
        if (r_q.state != ST_LOCK) begin
            if (line_edge)               r_d.cnt = CNT_ONE;
            else if (r_q.cnt != CNT_SAT) r_d.cnt = r_q.cnt + 1'b1;
        end

        unique case (r_q.state)
            ST_HUNT: begin
                if (line_edge && !rx_s) r_d.state = ST_MEAS;
            end
            ST_MEAS: begin
                if (line_edge) begin
                    take = 1'b1;
                    if (st_count == LAST_IDX) r_d.state = ST_CHECK;
                end else if (r_q.cnt == CNT_SAT) begin
                    r_d.state = ST_HUNT;
                end
            end
            ST_CHECK: begin
                if (meas_ok) begin
                    r_d.state   = ST_LOCK;
                    r_d.divisor = mean;
                    r_d.half    = {1'b0, mean[CNT_W-1:1]};
                    r_d.locked  = 1'b1;
                    r_d.echo    = 1'b1;
                end else begin
                    r_d.state = ST_HUNT;
                end
            end
            ST_LOCK: begin
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_HUNT, cnt: '0, rx_prev: 1'b1, divisor: '0,
                     half: '0, locked: 1'b0, echo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign divisor_o  = r_q.divisor;
    assign half_o     = r_q.half;
    assign locked_o   = r_q.locked;
    assign echo_req_o = r_q.echo;
endmodule

// File: rtl/ab_checker.sv
module ab_checker #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned MIN_DIV = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             locked,
    input logic             echo,
    input logic [CNT_W-1:0] divisor,
    input logic [CNT_W-1:0] half
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DIV);

    p_unlocked_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (divisor == '0 && half == '0));

    p_half_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (half == (divisor >> 1)));

    p_min_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (divisor >= MIN_V));

    p_echo_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        echo |=> !echo);

    p_echo_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> echo);

    p_echo_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        echo |-> locked);

    p_lock_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(divisor) && $stable(half)));
endmodule

bind autobaud_lock ab_checker #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_ab_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .locked  (locked_o),
    .echo    (echo_req_o),
    .divisor (divisor_o),
    .half    (half_o)
);

// File: tb/tb_autobaud_lock.sv
`timescale 1ns/1ps
module tb_autobaud_lock;
    localparam int unsigned CNT_W   = 10;
    localparam int unsigned MIN_DIV = 8;
    localparam int unsigned SYNC    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic [CNT_W-1:0] divisor;
    logic [CNT_W-1:0] half;
    logic             locked;
    logic             echo;

    int checks = 0;
    int errors = 0;
    int echo_cnt = 0;
    int cells [9];
    bit done = 1'b0;

    always #2 clk = ~clk;

    autobaud_lock #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV), .SYNC_STAGES(SYNC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx),
        .divisor_o  (divisor),
        .half_o     (half),
        .locked_o   (locked),
        .echo_req_o (echo)
    );

    always @(negedge clk) if (rst_n && echo) echo_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rx = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        echo_cnt = 0;
    endtask

    task automatic fill(input int w);
        for (int i = 0; i < 9; i++) cells[i] = w;
    endtask

    // idle, then nine alternating cells starting low, then the stop level
    task automatic send_char();
        rx = 1'b1;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            rx = (i % 2 == 0) ? 1'b0 : 1'b1;
            repeat (cells[i]) @(negedge clk);
        end
        rx = 1'b1;
    endtask

    task automatic expect_lock(input string tag, input int exp_div);
        repeat (SYNC + 1) @(negedge clk);
        chk({tag, " R9 no early lock"}, int'(locked), 0);
        @(negedge clk);
        chk({tag, " R9 lock cycle"}, int'(locked), 1);
        chk({tag, " R6 echo with lock"}, int'(echo), 1);
        chk({tag, " R2 divisor"}, int'(divisor), exp_div);
        chk({tag, " R2 half"}, int'(half), exp_div / 2);
        @(negedge clk);
        chk({tag, " R6 echo one cycle"}, int'(echo), 0);
        chk({tag, " R6 echo count"}, echo_cnt, 1);
    endtask

    task automatic expect_reject(input string tag);
        repeat (12) @(negedge clk);
        chk({tag, " locked"}, int'(locked), 0);
        chk({tag, " echo count"}, echo_cnt, 0);
        chk({tag, " R1 divisor zero"}, int'(divisor), 0);
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 locked", int'(locked), 0);
        chk("R1 echo", int'(echo), 0);
        chk("R1 divisor", int'(divisor), 0);
        chk("R1 half", int'(half), 0);
    endtask

    task automatic test_plain();
        do_reset();
        fill(16);
        send_char();
        expect_lock("R2 D=16", 16);
        do_reset();
        fill(41);
        send_char();
        expect_lock("R2 D=41", 41);
    endtask

    task automatic test_average();
        do_reset();
        cells = '{20, 21, 19, 22, 20, 18, 21, 20, 20};
        send_char();
        expect_lock("R3 jitter mean 161/8", 20);
        do_reset();
        cells = '{24, 25, 24, 25, 24, 25, 24, 25, 25};
        send_char();
        expect_lock("R3 floor 196/8", 24);
    endtask

    task automatic test_tolerance();
        do_reset();
        fill(16); cells[8] = 20;
        send_char();
        expect_lock("R4 upper edge 20", 16);
        do_reset();
        fill(16); cells[8] = 12;
        send_char();
        expect_lock("R4 lower edge 12", 16);
        do_reset();
        fill(16); cells[8] = 21;
        send_char();
        expect_reject("R4 cell 21");
        fill(16); cells[3] = 11;
        send_char();
        expect_reject("R4 cell 11");
        fill(24);
        send_char();
        expect_lock("R4 recover", 24);
    endtask

    task automatic test_min_period();
        do_reset();
        fill(4);
        send_char();
        expect_reject("R5 D=4");
        fill(7);
        send_char();
        expect_reject("R5 D=7");
        fill(MIN_DIV);
        send_char();
        expect_lock("R5 D=min", MIN_DIV);
    endtask

    task automatic test_stall();
        do_reset();
        rx = 1'b0;
        repeat (1100) @(negedge clk);
        rx = 1'b1;
        expect_reject("R8 stuck low");
        fill(16);
        send_char();
        expect_lock("R8 after abort", 16);
    endtask

    task automatic test_ignore();
        do_reset();
        fill(30);
        send_char();
        expect_lock("R7 first", 30);
        fill(12);
        send_char();
        repeat (20) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            rx = ~rx;
            repeat (3) @(negedge clk);
        end
        rx = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 still locked", int'(locked), 1);
        chk("R7 divisor held", int'(divisor), 30);
        chk("R7 half held", int'(half), 15);
        chk("R7 no new echo", echo_cnt, 1);
    endtask

    initial begin
        test_reset();
        test_plain();
        test_average();
        test_tolerance();
        test_min_period();
        test_stall();
        test_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule